// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the single load-reserved reservation that one hart may hold and rules on every store-conditional that follows. A load-reserved command records the requested address and access size, and the block returns the fetched data to the register file. For a word access the data is sign-extended to the full register width. A store-conditional succeeds only when a live reservation covers exactly the same address and size. In that case the block returns 0 and raises a store enable. Otherwise it returns the fixed code 1 and keeps the store from happening.

The reservation is lost when another hart is seen writing anywhere in the reserved 8-byte granule, on a context-switch pulse, or when any store-conditional executes. A newer load-reserved replaces it. Under the natural-alignment rule, a misaligned command raises an exception in place of a response and has no effect of its own.

All results are registered and appear exactly one clock after the command is sampled.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset, and in any cycle after one with no command, `resp_valid`, `sc_store_en` and `misalign_exc` are 0. A store-conditional issued straight after reset fails.
- R2: An aligned load-reserved (`lr_req`=1) yields `resp_valid`=1 one cycle later. `resp_data` equals `lr_data` for a doubleword (`req_dword`=1). For a word (`req_dword`=0) it equals `lr_data[31:0]` sign-extended from bit 31. The command also sets the reservation to its address and size.
- R3: An aligned store-conditional (`sc_req`=1) whose address and size equal those of a live reservation yields `resp_valid`=1, `resp_data`=0 and `sc_store_en`=1.
- R4: A store-conditional with no live reservation, or with a different address or a different size, yields `resp_valid`=1, `resp_data`=1 and `sc_store_en`=0.
- R5: Every aligned store-conditional clears the reservation, whether it passes or fails.
- R6: A snooped write (`snoop_valid`=1) clears the reservation when `snoop_addr[ADDR_W-1:3]` equals the reserved address bits `[ADDR_W-1:3]`. A snoop to any other granule leaves the reservation in place.
- R7: A `ctx_switch` pulse clears the reservation.
- R8: A command is misaligned when `req_addr[1:0]`≠0 for a word, or `req_addr[2:0]`≠0 for a doubleword. It then gives `misalign_exc`=1 one cycle later, with `resp_valid`=0 and `sc_store_en`=0, and it leaves the reservation unchanged.
- R9: A new aligned load-reserved replaces any existing reservation. A store-conditional to the older address then fails.
- R10: Same-cycle rules:
  - A snoop hit or `ctx_switch` arriving with a store-conditional makes that store-conditional fail.
  - A snoop to the new granule, or a `ctx_switch`, arriving with a load-reserved leaves no reservation.
  - When `lr_req` and `sc_req` are both 1, the load-reserved executes and the store-conditional is ignored.
- R11: Each command produces its outputs exactly one clock after it is sampled, and `sc_store_en` is only ever raised in the cycle after a store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_req | input | 1 | Load-reserved command |
| sc_req | input | 1 | Store-conditional command |
| req_addr | input | ADDR_W | Command byte address |
| req_dword | input | 1 | 1 = doubleword, 0 = word access |
| lr_data | input | XLEN | Data fetched for the load-reserved |
| snoop_valid | input | 1 | Write by another hart observed |
| snoop_addr | input | ADDR_W | Address of the observed write |
| ctx_switch | input | 1 | Preemptive context-switch pulse |
| resp_valid | output | 1 | Result for the destination register is valid |
| resp_data | output | XLEN | Load data, or store-conditional code (0 pass, 1 fail) |
| sc_store_en | output | 1 | Store-conditional write permitted |
| misalign_exc | output | 1 | Misaligned-address exception |

## Verification
Each result, whether load data, pass/fail code, store enable or exception, is due on the first rising edge after the command is driven. A reservation cleared by a snoop or context switch shows up as the result of the next store-conditional.

The driver applies one command per cycle at the falling edge. It pushes the expected outputs for that cycle into a queue, built from its own reservation model. The monitor pops one entry 1 ns after each rising edge and compares it, so every entry is checked in exactly the cycle it falls due.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int ADDR_W   = 32,
  parameter int XLEN     = 64,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_req,
  input  logic              sc_req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_dword,
  input  logic [XLEN-1:0]   lr_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              ctx_switch,
  output logic              resp_valid,
  output logic [XLEN-1:0]   resp_data,
  output logic              sc_store_en,
  output logic              misalign_exc
);
  localparam int WORD_W = 32;
  localparam logic [XLEN-1:0] FAIL_CODE = XLEN'(1);

  logic              rsv_vld;
  logic [ADDR_W-1:0] rsv_addr;
  logic              rsv_dw;

  logic misal, do_lr, do_sc, snp_hit_rsv, snp_hit_req, kill, sc_ok;
  logic [XLEN-1:0] lr_ext;

  assign misal       = req_dword ? (req_addr[2:0] != 3'd0) : (req_addr[1:0] != 2'd0);
  assign do_lr       = lr_req;
  assign do_sc       = sc_req && !lr_req;
  assign snp_hit_rsv = snoop_valid && (snoop_addr[ADDR_W-1:GRAN_LSB] == rsv_addr[ADDR_W-1:GRAN_LSB]);
  assign snp_hit_req = snoop_valid && (snoop_addr[ADDR_W-1:GRAN_LSB] == req_addr[ADDR_W-1:GRAN_LSB]);
  assign kill        = ctx_switch || (rsv_vld && snp_hit_rsv);
  assign sc_ok       = do_sc && !misal && rsv_vld && !kill
                       && (rsv_addr == req_addr) && (rsv_dw == req_dword);
  assign lr_ext      = req_dword ? lr_data
                       : {{(XLEN-WORD_W){lr_data[WORD_W-1]}}, lr_data[WORD_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_vld  <= 1'b0;
      rsv_addr <= '0;
      rsv_dw   <= 1'b0;
    end else if (do_lr && !misal) begin
      rsv_vld  <= !(ctx_switch || snp_hit_req);
      rsv_addr <= req_addr;
      rsv_dw   <= req_dword;
    end else if ((do_sc && !misal) || kill) begin
      rsv_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_data    <= '0;
      sc_store_en  <= 1'b0;
      misalign_exc <= 1'b0;
    end else begin
      resp_valid   <= (do_lr || do_sc) && !misal;
      sc_store_en  <= sc_ok;
      misalign_exc <= (do_lr || do_sc) && misal;
      if (do_lr && !misal)      resp_data <= lr_ext;
      else if (do_sc && !misal) resp_data <= sc_ok ? '0 : FAIL_CODE;
      else                      resp_data <= '0;
    end
  end
endmodule

module lrsc_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lr_req,
  input logic              sc_req,
  input logic [ADDR_W-1:0] req_addr,
  input logic              ctx_switch,
  input logic              resp_valid,
  input logic [XLEN-1:0]   resp_data,
  input logic              sc_store_en,
  input logic              misalign_exc
);
  // R3
  store_only_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_store_en |-> (resp_valid && resp_data == '0));
  // R8
  exc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_exc |-> (!resp_valid && !sc_store_en));
  // R11
  store_follows_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_store_en |-> $past(sc_req && !lr_req));
  // R7
  ctx_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch |=> !sc_store_en);
  // R4
  sc_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(sc_req && !lr_req)) |-> (resp_data == '0 || resp_data == XLEN'(1)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lr_req || sc_req) |=> (!resp_valid && !misalign_exc && !sc_store_en));
  // R5
  back_to_back_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !lr_req && req_addr[2:0] == 3'd0) ##1 (sc_req && !lr_req) |=> !sc_store_en);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_chk (.*);

// File: tb/tb_lrsc_monitor.sv
`timescale 1ns/1ps
module tb_lrsc_monitor;
  logic        clk = 0, rst_n = 0;
  logic        lr_req = 0, sc_req = 0, req_dword = 0, snoop_valid = 0, ctx_switch = 0;
  logic [31:0] req_addr = 0, snoop_addr = 0;
  logic [63:0] lr_data = 0;
  logic        resp_valid, sc_store_en, misalign_exc;
  logic [63:0] resp_data;

  always #2.5 clk = ~clk;

  lrsc_monitor #(.ADDR_W(32), .XLEN(64), .GRAN_LSB(3)) dut (.*);

  typedef struct {
    logic v; logic [63:0] d; logic st; logic ex; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0;
  bit m_vld = 0; logic [31:0] m_addr = 0; bit m_dw = 0;

  task automatic step(input bit lr, input bit sc, input logic [31:0] a, input bit dw,
                      input logic [63:0] d, input bit snp, input logic [31:0] sa,
                      input bit ctx, input string tag);
    exp_t e; bit mis, kill, hitreq, ok;
    @(negedge clk);
    lr_req = lr; sc_req = sc; req_addr = a; req_dword = dw; lr_data = d;
    snoop_valid = snp; snoop_addr = sa; ctx_switch = ctx;
    mis    = dw ? (a[2:0] != 0) : (a[1:0] != 0);
    kill   = ctx || (snp && m_vld && sa[31:3] == m_addr[31:3]);
    hitreq = snp && sa[31:3] == a[31:3];
    e.v = 0; e.d = 0; e.st = 0; e.ex = 0; e.tag = tag;
    if (lr) begin
      if (mis) begin e.ex = 1; if (kill) m_vld = 0; end
      else begin
        e.v = 1; e.d = dw ? d : {{32{d[31]}}, d[31:0]};
        m_vld = !(ctx || hitreq); m_addr = a; m_dw = dw;
      end
    end else if (sc) begin
      if (mis) begin e.ex = 1; if (kill) m_vld = 0; end
      else begin
        ok = m_vld && !kill && m_addr == a && m_dw == dw;
        e.v = 1; e.d = ok ? 64'd0 : 64'd1; e.st = ok; m_vld = 0;
      end
    end else if (kill) m_vld = 0;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial forever begin
    exp_t e;
    @(posedge clk); #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (resp_valid !== e.v || resp_data !== e.d || sc_store_en !== e.st || misalign_exc !== e.ex) begin
        failures++;
        $display("FAIL %s: got v=%0b d=%h st=%0b ex=%0b expected v=%0b d=%h st=%0b ex=%0b",
                 e.tag, resp_valid, resp_data, sc_store_en, misalign_exc, e.v, e.d, e.st, e.ex);
      end
    end
  end

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL R11 watchdog: got still running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [31:0] A = 32'h100, B = 32'h200;
  initial begin
    repeat (3) @(posedge clk);
    #1; checks++;
    if (resp_valid !== 0 || sc_store_en !== 0 || misalign_exc !== 0) begin
      failures++;
      $display("FAIL R1 reset: got v=%0b st=%0b ex=%0b expected 0 0 0", resp_valid, sc_store_en, misalign_exc);
    end
    @(negedge clk); rst_n = 1;
    step(0, 1, A, 1, 0, 0, 0, 0, "R1 sc after reset");
    step(1, 0, A, 0, 64'h0000_0000_8000_0001, 0, 0, 0, "R2 lr word sext");
    step(0, 1, A, 0, 0, 0, 0, 0, "R3 sc match");
    step(0, 1, A, 0, 0, 0, 0, 0, "R5 second sc");
    step(1, 0, A, 1, 64'hDEAD_BEEF_1234_5678, 0, 0, 0, "R2 lr dword");
    step(0, 1, A, 0, 0, 0, 0, 0, "R4 size mismatch");
    step(1, 0, A, 0, 64'h7FFF_FFFF, 0, 0, 0, "R2 lr word positive");
    step(0, 1, A + 4, 0, 0, 0, 0, 0, "R4 addr mismatch");
    step(1, 0, A, 0, 1, 0, 0, 0, "R6 lr");
    idle("R6 idle");
    step(0, 0, 0, 0, 0, 1, A + 8, 0, "R6 snoop other granule");
    step(0, 1, A, 0, 0, 0, 0, 0, "R6 sc survives");
    step(1, 0, A, 0, 1, 0, 0, 0, "R6 lr");
    step(0, 0, 0, 0, 0, 1, A + 4, 0, "R6 snoop same granule");
    step(0, 1, A, 0, 0, 0, 0, 0, "R6 sc after hit");
    step(1, 0, A, 1, 2, 0, 0, 0, "R7 lr");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R7 ctx switch");
    step(0, 1, A, 1, 0, 0, 0, 0, "R7 sc after ctx");
    step(1, 0, A, 0, 3, 0, 0, 0, "R8 lr");
    step(1, 0, B + 2, 0, 4, 0, 0, 0, "R8 misaligned word lr");
    step(1, 0, B + 4, 1, 4, 0, 0, 0, "R8 misaligned dword lr");
    step(0, 1, A + 1, 0, 0, 0, 0, 0, "R8 misaligned sc");
    step(0, 1, A, 0, 0, 0, 0, 0, "R8 reservation kept");
    step(1, 0, A, 0, 5, 0, 0, 0, "R9 lr old");
    step(1, 0, B, 0, 6, 0, 0, 0, "R9 lr new");
    step(0, 1, A, 0, 0, 0, 0, 0, "R9 sc old addr");
    step(1, 0, A, 0, 7, 0, 0, 0, "R10 lr");
    step(0, 1, A, 0, 0, 1, A, 0, "R10 snoop with sc");
    step(1, 0, A, 0, 7, 0, 0, 0, "R10 lr");
    step(0, 1, A, 0, 0, 0, 0, 1, "R10 ctx with sc");
    step(1, 0, A, 0, 8, 1, A + 2, 0, "R10 snoop with lr");
    step(0, 1, A, 0, 0, 0, 0, 0, "R10 sc after killed lr");
    step(1, 1, B, 1, 64'h55, 0, 0, 0, "R10 lr and sc together");
    step(0, 1, B, 1, 0, 0, 0, 0, "R10 sc after lr wins");
    idle("R11 idle");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] addrs [5];
      addrs = '{32'h100, 32'h104, 32'h108, 32'h102, 32'h200};
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, addrs[$urandom_range(0, 4)],
           $urandom_range(0, 1) == 1, {$urandom, $urandom}, $urandom_range(0, 5) == 0,
           addrs[$urandom_range(0, 4)], $urandom_range(0, 9) == 0, "R11 random mix");
    end
    idle("R11 drain");
    idle("R11 drain");
    @(posedge clk); #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule